// File: doc/BRIEF.md
# Power Management Event Router

This block gathers power management events into sticky status bits, each paired with an enable bit, and forwards the pending enabled events to two interrupt outputs. One output serves a legacy handler (SMI) and the other an ACPI driver (SCI). Each output has its own routing enable, held in a separate register. Either path, both paths or neither may be enabled at once. Every event is captured on the rising edge of its input line. A status bit is cleared by writing 1 to it.

A real-time-clock alarm input feeds two independent status/enable pairs. One pair sits beside the general events on the SCI path. The other drives an active-low PME wake output that no routing bit gates. The SCI pin has a programmable active level and can run as a push-pull driver or as an open-collector driver. In open-collector mode the pin only pulls low and otherwise releases the line. Software reaches all state through a flat register port with a combinational read.

Top module: `pm_evt_router`

## Requirements
- R1: After reset every register reads 0, smiOut is 0, pmeN is 1, sciData is 1 and sciOeN is 0 (active-low SCI, push-pull, inactive).
- R2: A rising edge on evtIn[i] sets status bit i at address 0, whatever the enables hold. An input held high does not set the bit again after it has been cleared.
- R3: Writing 1 to a status bit clears it and writing 0 leaves it unchanged. This applies to address 0 (bits [NUM_EVT-1:0] and bit 7) and to address 4 bit 0.
- R4: When a rising edge and a write-1 clear hit the same status bit in the same cycle, the bit ends up set.
- R5: smiOut is 1 exactly when bit 7 of address 3 is set and at least one status bit at address 0 has its matching enable bit at address 1 set.
- R6: The SCI is asserted exactly when bit 0 of address 2 is set and the same pending condition as R5 holds. R5 and R6 act independently, so both outputs may be active together.
- R7: A rising edge on rtcAlarm sets both the SCI-path RTC status (address 0 bit 7) and the PME status (address 4 bit 0). pmeN is 0 exactly when address 4 bit 0 and address 5 bit 0 are both set, and no routing bit affects it.
- R8: At address 6, bit 0 selects the SCI active level (1 = high) and bit 1 selects open-collector drive. In push-pull mode sciOeN is 0 and sciData carries the level. In open-collector mode sciData is 0 and sciOeN is 1 (released) when the level is high.
- R9: Unimplemented bits and address 7 read 0. Only bit 0 of address 2 and bit 7 of address 3 are stored in those registers.
- R10: The SCI-path RTC status counts as pending only when its enable, address 1 bit 7, is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| evtIn | input | NUM_EVT | General event lines, captured on rising edge |
| rtcAlarm | input | 1 | RTC alarm line, captured on rising edge |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Register address |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Combinational read data for regAddr |
| smiOut | output | 1 | Legacy interrupt, active high |
| pmeN | output | 1 | Wake event output, active low |
| sciData | output | 1 | SCI pin data value |
| sciOeN | output | 1 | SCI pin output enable, active low |

## Verification
The hardest case to reach from the ports is a rising edge that arrives in the same clock as a write-1 clear of its own bit. The bench drives the event line and the register write at the same falling edge, so both reach the same rising edge, and then reads the bit back. A second hard case is an event line held high across a clear. The bench keeps the line high, clears the bit, waits several cycles and confirms that the bit stays clear.

// File: rtl/pm_evt_pkg.sv
package pm_evt_pkg;
  localparam int REG_W       = 8;
  localparam int ADDR_W      = 3;
  localparam int RTC_STS_BIT = 7;
  localparam int SCI_EN_BIT  = 0;
  localparam int SMI_EN_BIT  = 7;
  localparam int CFG_POL_BIT = 0;
  localparam int CFG_OC_BIT  = 1;

  typedef enum logic [ADDR_W-1:0] {
    ADR_STS    = 3'd0,
    ADR_EN     = 3'd1,
    ADR_CTL    = 3'd2,
    ADR_SMI    = 3'd3,
    ADR_PMESTS = 3'd4,
    ADR_PMEEN  = 3'd5,
    ADR_CFG    = 3'd6
  } regAddrE;

  typedef struct packed {
    logic             wrSts;
    logic             wrEn;
    logic             wrCtl;
    logic             wrSmi;
    logic             wrPmeSts;
    logic             wrPmeEn;
    logic             wrCfg;
    logic [REG_W-1:0] data;
  } strobeT;

  typedef struct packed {
    logic [REG_W-1:0] sts;
    logic [REG_W-1:0] en;
    logic [REG_W-1:0] ctl;
    logic [REG_W-1:0] smi;
    logic [REG_W-1:0] pmeSts;
    logic [REG_W-1:0] pmeEn;
    logic [REG_W-1:0] cfg;
  } regViewT;
endpackage

// File: rtl/pm_evt_ctrl.sv
module pm_evt_ctrl
  import pm_evt_pkg::*;
(
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [REG_W-1:0]  regWrData,
  input  regViewT           view,
  output strobeT            strb,
  output logic [REG_W-1:0]  regRdData
);
  always_comb begin
    strb      = '0;
    strb.data = regWrData;
    if (regWrEn) begin
      case (regAddr)
        ADR_STS:    strb.wrSts    = 1'b1;
        ADR_EN:     strb.wrEn     = 1'b1;
        ADR_CTL:    strb.wrCtl    = 1'b1;
        ADR_SMI:    strb.wrSmi    = 1'b1;
        ADR_PMESTS: strb.wrPmeSts = 1'b1;
        ADR_PMEEN:  strb.wrPmeEn  = 1'b1;
        ADR_CFG:    strb.wrCfg    = 1'b1;
        default:    ;
      endcase
    end
  end

  always_comb begin
    case (regAddr)
      ADR_STS:    regRdData = view.sts;
      ADR_EN:     regRdData = view.en;
      ADR_CTL:    regRdData = view.ctl;
      ADR_SMI:    regRdData = view.smi;
      ADR_PMESTS: regRdData = view.pmeSts;
      ADR_PMEEN:  regRdData = view.pmeEn;
      ADR_CFG:    regRdData = view.cfg;
      default:    regRdData = '0;
    endcase
  end
endmodule

// File: rtl/pm_evt_datapath.sv
module pm_evt_datapath
  import pm_evt_pkg::*;
#(
  parameter int NUM_EVT = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_EVT-1:0] evtIn,
  input  logic               rtcAlarm,
  input  strobeT             strb,
  output regViewT            view,
  output logic               smiOut,
  output logic               pmeN,
  output logic               sciData,
  output logic               sciOeN
);
  logic [NUM_EVT-1:0] evtPrev, evtRise, evtSts, evtEn;
  logic rtcPrev, rtcRise;
  logic rtcSciSts, rtcSciEn, rtcPmeSts, rtcPmeEn;
  logic sciRouteEn, smiRouteEn, cfgPol, cfgOc;
  logic pending, sciActive, sciLevel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      evtPrev <= '0;
      rtcPrev <= 1'b0;
    end else begin
      evtPrev <= evtIn;
      rtcPrev <= rtcAlarm;
    end
  end

  assign evtRise = evtIn & ~evtPrev;
  assign rtcRise = rtcAlarm & ~rtcPrev;

  for (genvar i = 0; i < NUM_EVT; i++) begin : g_evt
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                            evtSts[i] <= 1'b0;
      else if (evtRise[i])                  evtSts[i] <= 1'b1;
      else if (strb.wrSts && strb.data[i])  evtSts[i] <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rtcSciSts <= 1'b0;
      rtcPmeSts <= 1'b0;
    end else begin
      if (rtcRise)                                     rtcSciSts <= 1'b1;
      else if (strb.wrSts && strb.data[RTC_STS_BIT])   rtcSciSts <= 1'b0;
      if (rtcRise)                                     rtcPmeSts <= 1'b1;
      else if (strb.wrPmeSts && strb.data[0])          rtcPmeSts <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      evtEn      <= '0;
      rtcSciEn   <= 1'b0;
      sciRouteEn <= 1'b0;
      smiRouteEn <= 1'b0;
      rtcPmeEn   <= 1'b0;
      cfgPol     <= 1'b0;
      cfgOc      <= 1'b0;
    end else begin
      if (strb.wrEn) begin
        evtEn    <= strb.data[NUM_EVT-1:0];
        rtcSciEn <= strb.data[RTC_STS_BIT];
      end
      if (strb.wrCtl)   sciRouteEn <= strb.data[SCI_EN_BIT];
      if (strb.wrSmi)   smiRouteEn <= strb.data[SMI_EN_BIT];
      if (strb.wrPmeEn) rtcPmeEn   <= strb.data[0];
      if (strb.wrCfg) begin
        cfgPol <= strb.data[CFG_POL_BIT];
        cfgOc  <= strb.data[CFG_OC_BIT];
      end
    end
  end

  assign pending   = (|(evtSts & evtEn)) | (rtcSciSts & rtcSciEn);
  assign smiOut    = smiRouteEn & pending;
  assign sciActive = sciRouteEn & pending;
  assign sciLevel  = cfgPol ? sciActive : ~sciActive;
  assign sciData   = cfgOc ? 1'b0 : sciLevel;
  assign sciOeN    = cfgOc ? sciLevel : 1'b0;
  assign pmeN      = ~(rtcPmeSts & rtcPmeEn);

  always_comb begin
    view = '0;
    view.sts[NUM_EVT-1:0]   = evtSts;
    view.sts[RTC_STS_BIT]   = rtcSciSts;
    view.en[NUM_EVT-1:0]    = evtEn;
    view.en[RTC_STS_BIT]    = rtcSciEn;
    view.ctl[SCI_EN_BIT]    = sciRouteEn;
    view.smi[SMI_EN_BIT]    = smiRouteEn;
    view.pmeSts[0]          = rtcPmeSts;
    view.pmeEn[0]           = rtcPmeEn;
    view.cfg[CFG_POL_BIT]   = cfgPol;
    view.cfg[CFG_OC_BIT]    = cfgOc;
  end

  // R2: a line already high cannot set a clear bit again
  assert_no_reset_on_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!evtSts[0] && evtPrev[0] && evtIn[0]) |=> !evtSts[0]);

  // R3: a write of 1 clears the bit when no edge competes
  assert_w1c_clears_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrSts && strb.data[0] && !evtRise[0]) |=> !evtSts[0]);

  // R3: a set PME status survives any write that does not carry 1 in bit 0
  assert_w1c_keep_R3: assert property (@(posedge clk) disable iff (!rstN)
    (rtcPmeSts && !(strb.wrPmeSts && strb.data[0])) |=> rtcPmeSts);

  // R4: an edge beats a same-cycle clear
  assert_set_wins_R4: assert property (@(posedge clk) disable iff (!rstN)
    (rtcRise && strb.wrPmeSts && strb.data[0]) |=> rtcPmeSts);

  // R7: an alarm edge lands in both status paths
  assert_rtc_both_R7: assert property (@(posedge clk) disable iff (!rstN)
    rtcRise |=> (rtcPmeSts && rtcSciSts));
endmodule

// File: rtl/pm_evt_router.sv
module pm_evt_router
  import pm_evt_pkg::*;
#(
  parameter int NUM_EVT = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_EVT-1:0] evtIn,
  input  logic               rtcAlarm,
  input  logic               regWrEn,
  input  logic [2:0]         regAddr,
  input  logic [7:0]         regWrData,
  output logic [7:0]         regRdData,
  output logic               smiOut,
  output logic               pmeN,
  output logic               sciData,
  output logic               sciOeN
);
  strobeT  strb;
  regViewT view;

  initial begin
    if (NUM_EVT < 1 || NUM_EVT > REG_W - 1)
      $error("NUM_EVT must lie between 1 and %0d", REG_W - 1);
  end

  pm_evt_ctrl u_ctrl (
    .regWrEn  (regWrEn),
    .regAddr  (regAddr),
    .regWrData(regWrData),
    .view     (view),
    .strb     (strb),
    .regRdData(regRdData)
  );

  pm_evt_datapath #(.NUM_EVT(NUM_EVT)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .evtIn   (evtIn),
    .rtcAlarm(rtcAlarm),
    .strb    (strb),
    .view    (view),
    .smiOut  (smiOut),
    .pmeN    (pmeN),
    .sciData (sciData),
    .sciOeN  (sciOeN)
  );
endmodule

// File: tb/pm_evt_router_tb.sv
`timescale 1ns/1ps
module pm_evt_router_tb;
  localparam int NUM_EVT = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NUM_EVT-1:0] evtIn = '0;
  logic rtcAlarm = 1'b0;
  logic regWrEn = 1'b0;
  logic [2:0] regAddr = '0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic smiOut, pmeN, sciData, sciOeN;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pm_evt_router #(.NUM_EVT(NUM_EVT)) u_dut (
    .clk(clk), .rstN(rstN), .evtIn(evtIn), .rtcAlarm(rtcAlarm),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .smiOut(smiOut), .pmeN(pmeN),
    .sciData(sciData), .sciOeN(sciOeN)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rdChk(input string tag, input logic [2:0] a, input logic [7:0] exp);
    regAddr = a;
    #1;
    chk(tag, regRdData, exp);
  endtask

  task automatic pulseEvt(input int i);
    @(negedge clk); evtIn[i] = 1'b1;
    @(negedge clk); evtIn[i] = 1'b0;
  endtask

  task automatic pulseRtc();
    @(negedge clk); rtcAlarm = 1'b1;
    @(negedge clk); rtcAlarm = 1'b0;
  endtask

  task automatic pins(input string tag, input logic s, input logic p, input logic d, input logic o);
    #1;
    chk({tag, " smiOut"}, smiOut, s);
    chk({tag, " pmeN"}, pmeN, p);
    chk({tag, " sciData"}, sciData, d);
    chk({tag, " sciOeN"}, sciOeN, o);
  endtask

  task automatic t_reset();
    for (int a = 0; a < 8; a++) rdChk("R1 reset read", 3'(a), 8'h00);
    pins("R1 reset", 1'b0, 1'b1, 1'b1, 1'b0);
  endtask

  task automatic t_edge();
    pulseEvt(1);
    rdChk("R2 edge sets bit1", 3'd0, 8'h02);
    @(negedge clk); evtIn[0] = 1'b1;
    @(negedge clk);
    rdChk("R2 held line sets bit0", 3'd0, 8'h03);
    wr(3'd0, 8'h03);
    repeat (3) @(negedge clk);
    rdChk("R2 held line no resets", 3'd0, 8'h00);
    evtIn[0] = 1'b0;
  endtask

  task automatic t_w1c();
    pulseEvt(2);
    pulseEvt(3);
    rdChk("R3 two set", 3'd0, 8'h0C);
    wr(3'd0, 8'h04);
    rdChk("R3 w1c one bit", 3'd0, 8'h08);
    wr(3'd0, 8'h00);
    rdChk("R3 write zero no effect", 3'd0, 8'h08);
    wr(3'd0, 8'h08);
    rdChk("R3 cleared", 3'd0, 8'h00);
  endtask

  task automatic t_route();
    wr(3'd1, 8'h08);
    pulseEvt(3);
    pins("R5 no routing", 1'b0, 1'b1, 1'b1, 1'b0);
    wr(3'd3, 8'h7F);
    rdChk("R9 smi reg only bit7", 3'd3, 8'h00);
    pins("R5 bit7 clear keeps smi off", 1'b0, 1'b1, 1'b1, 1'b0);
    wr(3'd3, 8'h80);
    pins("R5 smi routed", 1'b1, 1'b1, 1'b1, 1'b0);
    wr(3'd2, 8'hFF);
    rdChk("R9 ctl reg only bit0", 3'd2, 8'h01);
    pins("R6 both routed", 1'b1, 1'b1, 1'b0, 1'b0);
    wr(3'd3, 8'h00);
    pins("R6 sci alone", 1'b0, 1'b1, 1'b0, 1'b0);
    wr(3'd1, 8'h00);
    pins("R6 enable off", 1'b0, 1'b1, 1'b1, 1'b0);
    wr(3'd0, 8'h08);
    rdChk("R3 cleanup", 3'd0, 8'h00);
  endtask

  task automatic t_rtc();
    pulseRtc();
    rdChk("R7 sci rtc status", 3'd0, 8'h80);
    rdChk("R7 pme status", 3'd4, 8'h01);
    pins("R10 rtc not enabled", 1'b0, 1'b1, 1'b1, 1'b0);
    wr(3'd5, 8'h01);
    pins("R7 pme asserted", 1'b0, 1'b0, 1'b1, 1'b0);
    wr(3'd4, 8'h01);
    pins("R7 pme cleared", 1'b0, 1'b1, 1'b1, 1'b0);
    rdChk("R7 sci status kept", 3'd0, 8'h80);
    wr(3'd1, 8'h80);
    pins("R10 rtc enabled drives sci", 1'b0, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_polarity();
    wr(3'd6, 8'h01);
    pins("R8 pp high active", 1'b0, 1'b1, 1'b1, 1'b0);
    wr(3'd6, 8'h03);
    pins("R8 oc high active release", 1'b0, 1'b1, 1'b0, 1'b1);
    wr(3'd6, 8'h02);
    pins("R8 oc low active pull", 1'b0, 1'b1, 1'b0, 1'b0);
    wr(3'd0, 8'h80);
    pins("R8 oc low idle release", 1'b0, 1'b1, 1'b0, 1'b1);
    wr(3'd6, 8'h00);
    pins("R8 pp low idle", 1'b0, 1'b1, 1'b1, 1'b0);
  endtask

  task automatic t_setwins();
    wr(3'd5, 8'h00);
    @(negedge clk);
    rtcAlarm = 1'b1; regWrEn = 1'b1; regAddr = 3'd4; regWrData = 8'h01;
    @(negedge clk);
    regWrEn = 1'b0; rtcAlarm = 1'b0;
    rdChk("R4 pme set wins", 3'd4, 8'h01);
    @(negedge clk);
    evtIn[2] = 1'b1; regWrEn = 1'b1; regAddr = 3'd0; regWrData = 8'h84;
    @(negedge clk);
    regWrEn = 1'b0; evtIn[2] = 1'b0;
    rdChk("R4 evt set wins, rtc cleared", 3'd0, 8'h04);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_edge();
    t_w1c();
    t_route();
    t_rtc();
    t_polarity();
    t_setwins();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule